// File: doc/BRIEF.md
# Register Alias Rename Table

This block sits at the rename stage of an out-of-order core. For every architectural register it tracks where the newest value lives. The value is either committed in a small retirement register file held inside the block, or still in flight in a numbered reorder buffer entry. Each cycle a group of micro-ops arrives, up to `RAT_ISSUE_W` of them, each with two source registers, an optional destination register and the reorder buffer entry already allocated to it. For every source the block reports the location of the value. A committed source comes with its value. An in-flight source comes with the producer's entry number, and also with the value when the reorder buffer marks that entry as done. This per-source answer is the data-hazard check that the issue logic applies before dispatch.

A source that names a destination written by an older micro-op in the same group is steered to that older op's entry. Such an entry cannot have a result yet. At the clock edge each destination is remapped to its new entry. The retire port writes the committed value into the retirement file. It clears the register's mapping only if the mapping still names the retiring entry. A flush returns every register to the committed copy.

Top module: `reg_alias_table`

## Requirements
- R1: After synchronous reset every register maps to the retirement file and every retirement value is zero.
- R2: A source whose register is not in flight reports inflight=0, tag=0, ready=1 and the retirement file value.
- R3: A source whose register is in flight (with no in-group producer) reports inflight=1 and the mapped entry number as its tag.
- R4: An in-flight source reports ready=1 and that entry's value when `rob_ready[tag]` is 1. Otherwise it reports ready=0 and value 0.
- R5: A valid slot with `issue_dst_en`=1 maps its destination to its `issue_tag` from the next cycle. When two slots of one group write the same register, the higher-numbered (younger) slot wins.
- R6: A source of slot s that matches the destination of a valid writing slot i<s takes the tag of the largest such i, with inflight=1, ready=0 and value 0, in the same cycle.
- R7: A commit with `commit_dst_en`=1 writes `commit_value` into the retirement file entry `commit_dst`. Sources read the new value from the next cycle.
- R8: A commit clears the mapping of `commit_dst` only when that mapping is in flight with tag equal to `commit_tag`. Otherwise the mapping is unchanged.
- R9: When an issue write and a commit clear hit the same register in one cycle, the issue write wins.
- R10: `flush` returns every mapping to the retirement file at the next edge. Issue writes in that cycle are discarded, and a commit in that cycle still writes the retirement file.
- R11: A slot with `issue_valid`=0 or `issue_dst_en`=0 changes no mapping and steers no younger source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | RAT_ISSUE_W | Slot holds a micro-op |
| issue_src_a | input | RAT_ISSUE_W*ARCH_W | First source register per slot |
| issue_src_b | input | RAT_ISSUE_W*ARCH_W | Second source register per slot |
| issue_dst_en | input | RAT_ISSUE_W | Slot writes a destination |
| issue_dst | input | RAT_ISSUE_W*ARCH_W | Destination register per slot |
| issue_tag | input | RAT_ISSUE_W*TAG_W | Reorder buffer entry allocated per slot |
| rob_ready | input | RAT_ROB_ENTRIES | Entry has its result |
| rob_value | input | RAT_ROB_ENTRIES*RAT_XLEN | Result per entry |
| commit_valid | input | 1 | An entry retires this cycle |
| commit_tag | input | TAG_W | Retiring entry number |
| commit_dst_en | input | 1 | Retiring entry writes a register |
| commit_dst | input | ARCH_W | Register written by the retiring entry |
| commit_value | input | RAT_XLEN | Value committed |
| flush | input | 1 | Mispredict recovery |
| opnd_inflight | output | RAT_ISSUE_W*2 | Operand k=slot*2+src comes from the reorder buffer |
| opnd_tag | output | RAT_ISSUE_W*2*TAG_W | Producer entry of operand k |
| opnd_ready | output | RAT_ISSUE_W*2 | Operand k has its value |
| opnd_value | output | RAT_ISSUE_W*2*RAT_XLEN | Value of operand k |

## Verification
The bench aims at stale commits, where an older entry retires after its register has been remapped. A table that cleared on the register number alone would send later consumers to the retirement file with an old value. It drives an issue and a commit to the same register in the same cycle, where the wrong priority loses the fresh mapping. It also drives flushes that carry an issue group, where an unflushed write would leave a dangling tag. Inside one group it repeats a destination and reads it back from younger slots, so a wrong slot priority or a missing bypass gives an older tag or a stale committed value.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int RAT_ARCH_REGS   = 8;
    localparam int RAT_ROB_ENTRIES = 16;
    localparam int RAT_XLEN        = 32;
    localparam int RAT_ISSUE_W     = 2;
    localparam int RAT_SRCS        = 2;

    localparam int ARCH_W = $clog2(RAT_ARCH_REGS);
    localparam int TAG_W  = $clog2(RAT_ROB_ENTRIES);
    localparam int OPND_N = RAT_ISSUE_W * RAT_SRCS;

    typedef logic [ARCH_W-1:0]   arch_idx_t;
    typedef logic [TAG_W-1:0]    rob_tag_t;
    typedef logic [RAT_XLEN-1:0] word_t;

    typedef enum logic {
        LOC_RETIRED  = 1'b0,
        LOC_INFLIGHT = 1'b1
    } loc_e;

    typedef struct packed {
        loc_e     loc;
        rob_tag_t tag;
    } map_entry_t;

    typedef struct packed {
        logic      valid;
        arch_idx_t src_a;
        arch_idx_t src_b;
        logic      dst_en;
        arch_idx_t dst;
        rob_tag_t  tag;
    } issue_slot_t;

    typedef struct packed {
        logic     hit;
        rob_tag_t tag;
    } bypass_t;

    typedef struct packed {
        loc_e     loc;
        rob_tag_t tag;
        logic     ready;
        word_t    value;
    } operand_t;

    localparam map_entry_t MAP_RETIRED = '{loc: LOC_RETIRED, tag: '0};

    function automatic logic slot_writes(issue_slot_t s, arch_idx_t r);
        return s.valid && s.dst_en && (s.dst == r);
    endfunction

    // youngest slot older than 'upto' that writes 'src'
    function automatic bypass_t group_bypass(issue_slot_t grp [RAT_ISSUE_W],
                                             int upto, arch_idx_t src);
        bypass_t b;
        b = '{hit: 1'b0, tag: '0};
        for (int i = 0; i < RAT_ISSUE_W; i++) begin
            if (i < upto && slot_writes(grp[i], src)) begin
                b.hit = 1'b1;
                b.tag = grp[i].tag;
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en  [RAT_ISSUE_W],
    input  arch_idx_t  wr_dst [RAT_ISSUE_W],
    input  rob_tag_t   wr_tag [RAT_ISSUE_W],
    input  logic       clr_en,
    input  arch_idx_t  clr_dst,
    input  rob_tag_t   clr_tag,
    input  logic       flush,
    output map_entry_t map_q [RAT_ARCH_REGS]
);

    for (genvar r = 0; r < RAT_ARCH_REGS; r++) begin : g_reg
        map_entry_t nxt;

        always_comb begin
            nxt = map_q[r];
            // retire only clears if this register still names the retiring entry
            if (clr_en && clr_dst == arch_idx_t'(r) &&
                map_q[r].loc == LOC_INFLIGHT && map_q[r].tag == clr_tag)
                nxt = MAP_RETIRED;
            // new issue mappings override; later slot is younger
            for (int s = 0; s < RAT_ISSUE_W; s++) begin
                if (wr_en[s] && wr_dst[s] == arch_idx_t'(r))
                    nxt = '{loc: LOC_INFLIGHT, tag: wr_tag[s]};
            end
            if (flush)
                nxt = MAP_RETIRED;
        end

        always_ff @(posedge clk) begin
            if (rst) map_q[r] <= MAP_RETIRED;
            else     map_q[r] <= nxt;
        end
    end

endmodule

// File: rtl/rat_retire_file.sv
module rat_retire_file
    import rat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  arch_idx_t waddr,
    input  word_t     wdata,
    output word_t     rf_q [RAT_ARCH_REGS]
);

    for (genvar r = 0; r < RAT_ARCH_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                rf_q[r] <= '0;
            else if (we && waddr == arch_idx_t'(r))
                rf_q[r] <= wdata;
        end
    end

endmodule

// File: rtl/rat_operand_steer.sv
module rat_operand_steer
    import rat_pkg::*;
(
    input  map_entry_t                 ent,
    input  word_t                      rrf_val,
    input  bypass_t                    fwd,
    input  logic [RAT_ROB_ENTRIES-1:0] rob_ready,
    input  word_t                      rob_val [RAT_ROB_ENTRIES],
    output operand_t                   opnd
);

    always_comb begin
        if (fwd.hit) begin
            // producer allocated this very cycle: no result can exist yet
            opnd = '{loc: LOC_INFLIGHT, tag: fwd.tag, ready: 1'b0, value: '0};
        end else if (ent.loc == LOC_INFLIGHT) begin
            opnd.loc   = LOC_INFLIGHT;
            opnd.tag   = ent.tag;
            opnd.ready = rob_ready[ent.tag];
            opnd.value = rob_ready[ent.tag] ? rob_val[ent.tag] : '0;
        end else begin
            opnd = '{loc: LOC_RETIRED, tag: '0, ready: 1'b1, value: rrf_val};
        end
    end

endmodule

// File: rtl/reg_alias_table.sv
module reg_alias_table
    import rat_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [RAT_ISSUE_W-1:0]          issue_valid,
    input  logic [RAT_ISSUE_W*ARCH_W-1:0]   issue_src_a,
    input  logic [RAT_ISSUE_W*ARCH_W-1:0]   issue_src_b,
    input  logic [RAT_ISSUE_W-1:0]          issue_dst_en,
    input  logic [RAT_ISSUE_W*ARCH_W-1:0]   issue_dst,
    input  logic [RAT_ISSUE_W*TAG_W-1:0]    issue_tag,
    input  logic [RAT_ROB_ENTRIES-1:0]      rob_ready,
    input  logic [RAT_ROB_ENTRIES*RAT_XLEN-1:0] rob_value,
    input  logic                            commit_valid,
    input  logic [TAG_W-1:0]                commit_tag,
    input  logic                            commit_dst_en,
    input  logic [ARCH_W-1:0]               commit_dst,
    input  logic [RAT_XLEN-1:0]             commit_value,
    input  logic                            flush,
    output logic [OPND_N-1:0]               opnd_inflight,
    output logic [OPND_N*TAG_W-1:0]         opnd_tag,
    output logic [OPND_N-1:0]               opnd_ready,
    output logic [OPND_N*RAT_XLEN-1:0]      opnd_value
);

    issue_slot_t slots  [RAT_ISSUE_W];
    logic        wr_en  [RAT_ISSUE_W];
    arch_idx_t   wr_dst [RAT_ISSUE_W];
    rob_tag_t    wr_tag [RAT_ISSUE_W];
    map_entry_t  map_q  [RAT_ARCH_REGS];
    word_t       rrf_q  [RAT_ARCH_REGS];
    word_t       rob_arr[RAT_ROB_ENTRIES];
    logic        retire_we;

    for (genvar e = 0; e < RAT_ROB_ENTRIES; e++) begin : g_rob
        assign rob_arr[e] = rob_value[e*RAT_XLEN +: RAT_XLEN];
    end

    assign retire_we = commit_valid && commit_dst_en;

    rat_map_table u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_dst  (wr_dst),
        .wr_tag  (wr_tag),
        .clr_en  (retire_we),
        .clr_dst (commit_dst),
        .clr_tag (commit_tag),
        .flush   (flush),
        .map_q   (map_q)
    );

    rat_retire_file u_rrf (
        .clk   (clk),
        .rst   (rst),
        .we    (retire_we),
        .waddr (commit_dst),
        .wdata (commit_value),
        .rf_q  (rrf_q)
    );

    for (genvar s = 0; s < RAT_ISSUE_W; s++) begin : g_slot
        assign slots[s] = '{valid:  issue_valid[s],
                            src_a:  issue_src_a[s*ARCH_W +: ARCH_W],
                            src_b:  issue_src_b[s*ARCH_W +: ARCH_W],
                            dst_en: issue_dst_en[s],
                            dst:    issue_dst[s*ARCH_W +: ARCH_W],
                            tag:    issue_tag[s*TAG_W +: TAG_W]};
        assign wr_en[s]  = slots[s].valid && slots[s].dst_en;
        assign wr_dst[s] = slots[s].dst;
        assign wr_tag[s] = slots[s].tag;

        for (genvar o = 0; o < RAT_SRCS; o++) begin : g_opnd
            localparam int K = s * RAT_SRCS + o;
            arch_idx_t src;
            bypass_t   byp;
            operand_t  res;

            assign src = (o == 0) ? slots[s].src_a : slots[s].src_b;

            always_comb byp = group_bypass(slots, s, src);

            rat_operand_steer u_steer (
                .ent       (map_q[src]),
                .rrf_val   (rrf_q[src]),
                .fwd       (byp),
                .rob_ready (rob_ready),
                .rob_val   (rob_arr),
                .opnd      (res)
            );

            assign opnd_inflight[K]                   = (res.loc == LOC_INFLIGHT);
            assign opnd_tag[K*TAG_W +: TAG_W]         = res.tag;
            assign opnd_ready[K]                      = res.ready;
            assign opnd_value[K*RAT_XLEN +: RAT_XLEN] = res.value;
        end
    end

endmodule

// File: rtl/reg_alias_table_chk.sv
module reg_alias_table_chk
    import rat_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [RAT_ISSUE_W-1:0]        issue_valid,
    input logic [RAT_ISSUE_W*ARCH_W-1:0] issue_src_a,
    input logic [RAT_ISSUE_W-1:0]        issue_dst_en,
    input logic [RAT_ISSUE_W*ARCH_W-1:0] issue_dst,
    input logic [RAT_ISSUE_W*TAG_W-1:0]  issue_tag,
    input logic                          commit_valid,
    input logic                          commit_dst_en,
    input logic [ARCH_W-1:0]             commit_dst,
    input logic [RAT_XLEN-1:0]           commit_value,
    input logic                          flush,
    input logic [OPND_N-1:0]             opnd_inflight,
    input logic [OPND_N*TAG_W-1:0]       opnd_tag,
    input logic [OPND_N-1:0]             opnd_ready,
    input logic [OPND_N*RAT_XLEN-1:0]    opnd_value
);

    logic      younger_same;
    arch_idx_t dst0;
    rob_tag_t  tag0;

    assign dst0 = issue_dst[ARCH_W-1:0];
    assign tag0 = issue_tag[TAG_W-1:0];

    always_comb begin
        younger_same = 1'b0;
        for (int s = 1; s < RAT_ISSUE_W; s++)
            if (issue_valid[s] && issue_dst_en[s] && issue_dst[s*ARCH_W +: ARCH_W] == dst0)
                younger_same = 1'b1;
    end

    // R2: a committed operand is always usable
    p_retired_ready_r2: assert property (@(posedge clk) disable iff (rst)
        ((~opnd_inflight & ~opnd_ready) == '0));

    // R4: in-flight but not done reads as zero
    p_notready_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (opnd_inflight[0] && !opnd_ready[0]) |-> (opnd_value[RAT_XLEN-1:0] == '0));

    // R5: slot 0 destination mapping visible next cycle
    p_issue_maps_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid[0] && issue_dst_en[0] && !flush && !younger_same) |=>
        (issue_src_a[ARCH_W-1:0] != $past(dst0) ||
         (opnd_inflight[0] && opnd_tag[TAG_W-1:0] == $past(tag0))));

    // R6: slot 1 first source bypassed from slot 0
    p_group_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid[0] && issue_dst_en[0] && issue_src_a[2*ARCH_W-1:ARCH_W] == dst0) |->
        (opnd_inflight[2] && !opnd_ready[2] && opnd_tag[3*TAG_W-1:2*TAG_W] == tag0));

    // R7: committed value seen next cycle by an unmapped reader
    p_commit_write_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_dst_en) |=>
        (issue_src_a[ARCH_W-1:0] != $past(commit_dst) || opnd_inflight[0] ||
         opnd_value[RAT_XLEN-1:0] == $past(commit_value)));

    // R10: after flush, slot 0 (never bypassed) reads committed state
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!opnd_inflight[0] && !opnd_inflight[1]));

endmodule

bind reg_alias_table reg_alias_table_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .issue_src_a   (issue_src_a),
    .issue_dst_en  (issue_dst_en),
    .issue_dst     (issue_dst),
    .issue_tag     (issue_tag),
    .commit_valid  (commit_valid),
    .commit_dst_en (commit_dst_en),
    .commit_dst    (commit_dst),
    .commit_value  (commit_value),
    .flush         (flush),
    .opnd_inflight (opnd_inflight),
    .opnd_tag      (opnd_tag),
    .opnd_ready    (opnd_ready),
    .opnd_value    (opnd_value)
);

// File: tb/reg_alias_table_test.sv
`timescale 1ns/1ps
module reg_alias_table_test;
    import rat_pkg::*;

    localparam int NR = RAT_ARCH_REGS;
    localparam int NE = RAT_ROB_ENTRIES;
    localparam int XW = RAT_XLEN;
    localparam int IW = RAT_ISSUE_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IW-1:0]        issue_valid;
    logic [IW*ARCH_W-1:0] issue_src_a, issue_src_b, issue_dst;
    logic [IW-1:0]        issue_dst_en;
    logic [IW*TAG_W-1:0]  issue_tag;
    logic [NE-1:0]        rob_ready;
    logic [NE*XW-1:0]     rob_value;
    logic                 commit_valid, commit_dst_en, flush;
    logic [TAG_W-1:0]     commit_tag;
    logic [ARCH_W-1:0]    commit_dst;
    logic [XW-1:0]        commit_value;
    logic [OPND_N-1:0]    opnd_inflight, opnd_ready;
    logic [OPND_N*TAG_W-1:0] opnd_tag;
    logic [OPND_N*XW-1:0]    opnd_value;

    int total = 0;
    int bad   = 0;

    // reference model state
    int m_pend [NR];
    int m_tag  [NR];
    longint m_rrf [NR];

    always #4 clk = ~clk;

    reg_alias_table uut (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
        .issue_dst_en(issue_dst_en), .issue_dst(issue_dst), .issue_tag(issue_tag),
        .rob_ready(rob_ready), .rob_value(rob_value),
        .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_dst_en(commit_dst_en),
        .commit_dst(commit_dst), .commit_value(commit_value), .flush(flush),
        .opnd_inflight(opnd_inflight), .opnd_tag(opnd_tag),
        .opnd_ready(opnd_ready), .opnd_value(opnd_value)
    );

    task automatic idle();
        issue_valid = '0; issue_src_a = '0; issue_src_b = '0; issue_dst_en = '0;
        issue_dst = '0; issue_tag = '0; rob_ready = '0; rob_value = '0;
        commit_valid = 0; commit_tag = '0; commit_dst_en = 0; commit_dst = '0;
        commit_value = '0; flush = 0;
    endtask

    task automatic set_slot(int s, bit v, int sa, int sb, bit de, int d, int t);
        issue_valid[s] = v;
        issue_src_a[s*ARCH_W +: ARCH_W] = ARCH_W'(sa);
        issue_src_b[s*ARCH_W +: ARCH_W] = ARCH_W'(sb);
        issue_dst_en[s] = de;
        issue_dst[s*ARCH_W +: ARCH_W] = ARCH_W'(d);
        issue_tag[s*TAG_W +: TAG_W] = TAG_W'(t);
    endtask

    task automatic set_commit(int t, int d, longint v);
        commit_valid = 1; commit_dst_en = 1;
        commit_tag = TAG_W'(t); commit_dst = ARCH_W'(d); commit_value = XW'(v);
    endtask

    task automatic check(bit ok, string req, int k, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s operand %0d %s actual=%h expected=%h", req, k, what, act, exp);
        end
    endtask

    task automatic compare(string phase);
        for (int k = 0; k < OPND_N; k++) begin
            int s, src, e_pend, e_tag, e_rdy, fwd;
            longint e_val;
            string rq1, rq2;
            s = k / RAT_SRCS;
            src = (k % RAT_SRCS == 1) ? int'(issue_src_b[s*ARCH_W +: ARCH_W])
                                      : int'(issue_src_a[s*ARCH_W +: ARCH_W]);
            fwd = -1;
            for (int i = 0; i < s; i++)
                if (issue_valid[i] && issue_dst_en[i] &&
                    int'(issue_dst[i*ARCH_W +: ARCH_W]) == src)
                    fwd = i;
            if (fwd >= 0) begin
                e_pend = 1; e_tag = int'(issue_tag[fwd*TAG_W +: TAG_W]); e_rdy = 0; e_val = 0;
            end else if (m_pend[src] != 0) begin
                e_pend = 1; e_tag = m_tag[src]; e_rdy = rob_ready[e_tag];
                e_val = e_rdy ? longint'(rob_value[e_tag*XW +: XW]) : 0;
            end else begin
                e_pend = 0; e_tag = 0; e_rdy = 1; e_val = m_rrf[src];
            end
            if (phase != "") begin rq1 = phase; rq2 = phase; end
            else begin
                rq1 = (fwd >= 0) ? "R6" : (e_pend != 0 ? "R3" : "R2");
                rq2 = "R4";
            end
            check(opnd_inflight[k] == e_pend[0] && int'(opnd_tag[k*TAG_W +: TAG_W]) == e_tag,
                  rq1, k, "loc/tag",
                  {opnd_inflight[k], 8'h0, 4'(opnd_tag[k*TAG_W +: TAG_W])},
                  {e_pend[0], 8'h0, 4'(e_tag)});
            check(opnd_ready[k] == e_rdy[0] && longint'(opnd_value[k*XW +: XW]) == e_val,
                  rq2, k, "ready/value",
                  {opnd_ready[k], 3'b0, opnd_value[k*XW +: XW]},
                  {e_rdy[0], 3'b0, XW'(e_val)});
        end
    endtask

    task automatic model_update();
        if (commit_valid && commit_dst_en) begin
            m_rrf[commit_dst] = longint'(commit_value);
            if (m_pend[commit_dst] != 0 && m_tag[commit_dst] == int'(commit_tag))
                m_pend[commit_dst] = 0;
        end
        for (int s = 0; s < IW; s++)
            if (issue_valid[s] && issue_dst_en[s]) begin
                m_pend[issue_dst[s*ARCH_W +: ARCH_W]] = 1;
                m_tag[issue_dst[s*ARCH_W +: ARCH_W]] = int'(issue_tag[s*TAG_W +: TAG_W]);
            end
        if (flush)
            for (int r = 0; r < NR; r++) m_pend[r] = 0;
    endtask

    // inputs set just after a falling edge; compare, advance, update model
    task automatic tick(string phase);
        #1;
        compare(phase);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic read_regs(int a0, int b0, int a1, int b1, string phase);
        idle();
        set_slot(0, 0, a0, b0, 0, 0, 0);
        set_slot(1, 0, a1, b1, 0, 0, 0);
        tick(phase);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin m_pend[r] = 0; m_tag[r] = 0; m_rrf[r] = 0; end
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state seen through all operands
        read_regs(0, 1, 2, 3, "R1");
        read_regs(4, 5, 6, 7, "R1");

        // R7: fill retirement file with unmapped commits
        for (int r = 1; r < NR; r++) begin
            idle(); set_commit(r, r, 64'h100 + r); tick("R7");
        end
        // R2: committed reads
        read_regs(1, 2, 3, 7, "R2");

        // R5: two slots write reg 3, younger wins
        idle();
        set_slot(0, 1, 0, 0, 1, 3, 5);
        set_slot(1, 1, 1, 1, 1, 3, 6);
        tick("R5");
        read_regs(3, 1, 3, 2, "R3");

        // R4: readiness of the mapped entry
        idle(); set_slot(0, 0, 3, 3, 0, 0, 0);
        rob_ready[6] = 1; rob_value[6*XW +: XW] = 32'hDEAD_BEEF;
        tick("R4");
        rob_ready[6] = 0;
        tick("R4");

        // R8: stale commit keeps mapping, matching commit clears it
        idle(); set_commit(5, 3, 64'h55); tick("R8");
        read_regs(3, 0, 3, 0, "R8");
        idle(); set_commit(6, 3, 64'h66); tick("R8");
        read_regs(3, 0, 3, 0, "R8");

        // R9: issue beats same-cycle commit clear
        idle(); set_slot(0, 1, 0, 0, 1, 2, 8); tick("R9");
        idle(); set_commit(8, 2, 64'h88); set_slot(0, 1, 0, 0, 1, 2, 9); tick("R9");
        read_regs(2, 2, 2, 0, "R9");

        // R6: in-group bypass, not ready even if entry flagged
        idle();
        set_slot(0, 1, 4, 4, 1, 4, 10);
        set_slot(1, 1, 4, 4, 1, 5, 11);
        rob_ready[10] = 1;
        tick("R6");

        // R10: flush discards issue, commit still writes
        idle();
        set_slot(0, 1, 0, 0, 1, 6, 12);
        set_commit(13, 6, 64'hABC);
        flush = 1;
        tick("R10");
        read_regs(4, 5, 6, 2, "R10");

        // R11: invalid slot and no-destination slot
        idle();
        set_slot(0, 0, 0, 0, 1, 1, 12);
        set_slot(1, 1, 1, 1, 0, 7, 13);
        tick("R11");
        read_regs(1, 7, 1, 7, "R11");

        // mixed traffic
        for (int c = 0; c < 4000; c++) begin
            idle();
            for (int s = 0; s < IW; s++)
                set_slot(s, $urandom_range(0, 3) != 0, $urandom_range(0, NR-1),
                         $urandom_range(0, NR-1), $urandom_range(0, 2) != 0,
                         $urandom_range(0, 3), $urandom_range(0, NE-1));
            rob_ready = NE'($urandom);
            for (int e = 0; e < NE; e++) rob_value[e*XW +: XW] = $urandom;
            if ($urandom_range(0, 1) == 1) begin
                int r;
                r = $urandom_range(0, NR-1);
                set_commit(($urandom_range(0, 1) == 1) ? m_tag[r] : $urandom_range(0, NE-1),
                           r, longint'($urandom));
                commit_dst_en = $urandom_range(0, 4) != 0;
            end
            flush = $urandom_range(0, 31) == 0;
            tick("");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule